// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Sense Control

This block gathers interrupt requests from eight active-low external request pins, one non-maskable request pin and a set of active-high internal peripheral request lines. Each request gets a programmable 4-bit priority. Every clock, the block reports the most urgent pending request to the processor as a level and a vector index. The processor clears a latched request by pulsing an acknowledge together with the vector it serviced.

Priorities are held in 16-bit registers. Each register has four 4-bit fields. The first eight fields belong to the external pins. The fields after them each serve one group of peripheral lines, and every line in a group shares that group's priority. A control register selects the sense mode of each external pin and the active edge of the non-maskable pin, and shows the synchronized level of that pin.

Software reaches all registers through a simple write strobe and a combinational read port. A standby input returns every register to its reset value.

Top module: `prio_intc`

## Requirements
- R1: Out of reset, every priority register reads 0x0000. The control register reads 0x8000 while the non-maskable pin is high. The output reads valid=0, level=0 and vector=0. Whenever nothing is reported, level and vector are 0.
- R2: Priority field f sits in register f/4 (bus address f/4). Field f%4 == 0 is at bits 15..12, 1 at bits 11..8, 2 at bits 7..4 and 3 at bits 3..0. A written field reads back unchanged.
- R3: The control register is at bus address 4. Bit 15 reads the synchronized non-maskable pin level. Bits 14..9 always read 0 and ignore writes. Bit 8 is the non-maskable edge select. Bit 7-i is the sense select of external pin i.
- R4: With sense bit 0, external pin i (vector i, priority field i) requests while its synchronized level is low, and stops requesting as soon as the pin is high again.
- R5: With sense bit 1, a falling edge on external pin i sets a latched request. The request stays set until an acknowledge with vector i. An acknowledge with any other vector leaves it set.
- R6: Peripheral line j of group g has vector 8+2g+j and uses priority field 8+g. Both lines of a group report the same level.
- R7: Among pending requests the highest priority is reported. The reported level equals that priority. On a tie the lowest vector wins.
- R8: A request whose priority field is 0 is never reported.
- R9: The non-maskable request is latched on a falling edge when bit 8 is 0, and on a rising edge when bit 8 is 1. It is reported as level 16 with vector 24 over any other request, and stays until acknowledged with vector 24.
- R10: A standby cycle clears every priority register and control bits 8..0.
- R11: External pins pass through two synchronizer flops, and the output is registered. A level-sensed pin change shows at the output on the third rising clock edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby_i | input | 1 | Synchronous return of all registers to reset values |
| irq_pin_n_i | input | 8 | External request pins, active low, bit i is pin i |
| nmi_pin_i | input | 1 | Non-maskable request pin |
| periph_req_i | input | 16 | Internal peripheral request lines, active high |
| bus_addr_i | input | 3 | Register address |
| bus_wr_i | input | 1 | Register write strobe |
| bus_wdata_i | input | 16 | Register write data |
| bus_rdata_o | output | 16 | Register read data for bus_addr_i |
| ack_i | input | 1 | Acknowledge strobe |
| ack_vec_i | input | 5 | Vector being acknowledged |
| int_valid_o | output | 1 | A request is being reported |
| int_level_o | output | 5 | Reported level, 16 for non-maskable |
| int_vec_o | output | 5 | Reported vector index |

## Verification
The assertions assume three things. An acknowledge is the only way the processor ends a latched request. A latched request drops only because of such an acknowledge or because its pin is switched to level sense. A pending non-maskable request outranks every setting of the priority fields. The stimulus holds every external pin for at least two clocks between changes, so no edge is lost in the synchronizers. It pulses acknowledges for one cycle. It changes sense modes only while the pins are idle high, so a mode switch never creates a false edge.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
  localparam int unsigned IRQ_PINS       = 8;
  localparam int unsigned FIELD_W        = 4;
  localparam int unsigned REG_W          = 16;
  localparam int unsigned FIELDS_PER_REG = REG_W / FIELD_W;
  localparam int unsigned LEVEL_W        = FIELD_W + 1;
  localparam logic [LEVEL_W-1:0] NMI_LEVEL = LEVEL_W'(16);

  function automatic int unsigned reg_count(input int unsigned nfield);
    return (nfield + FIELDS_PER_REG - 1) / FIELDS_PER_REG;
  endfunction
endpackage

// File: rtl/prio_intc_sync.sv
module prio_intc_sync #(
  parameter int unsigned W       = 1,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= {W{RST_VAL}};
      stage2_q <= {W{RST_VAL}};
    end else begin
      stage1_q <= async_i;
      stage2_q <= stage1_q;
    end
  end

  assign sync_o = stage2_q;
endmodule

// File: rtl/prio_intc_regs.sv
module prio_intc_regs
  import prio_intc_pkg::*;
#(
  parameter int unsigned FIELD_CNT = 16,
  parameter int unsigned REG_CNT   = 4,
  parameter int unsigned ADDR_W    = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         standby_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic                         wr_i,
  input  logic [REG_W-1:0]             wdata_i,
  input  logic                         nmi_level_i,
  output logic [REG_W-1:0]             rdata_o,
  output logic [FIELD_CNT*FIELD_W-1:0] fields_o,
  output logic [IRQ_PINS-1:0]          sense_o,
  output logic                         nmi_rise_o
);
  localparam int unsigned CTRL_W = IRQ_PINS + 1;
  localparam int unsigned RSVD_W = REG_W - CTRL_W - 1;

  logic [FIELD_CNT*FIELD_W-1:0] fields_q, fields_d;
  logic [CTRL_W-1:0]            ctrl_q, ctrl_d;
  logic                         ctrl_sel;

  assign ctrl_sel = (addr_i == ADDR_W'(REG_CNT));

  always_comb begin
    fields_d = fields_q;
    ctrl_d   = ctrl_q;
    if (standby_i) begin
      fields_d = '0;
      ctrl_d   = '0;
    end else if (wr_i) begin
      if (ctrl_sel) begin
        ctrl_d = wdata_i[CTRL_W-1:0];
      end else begin
        for (int f = 0; f < FIELD_CNT; f++) begin
          if (addr_i == ADDR_W'(f / FIELDS_PER_REG)) begin
            fields_d[f*FIELD_W +: FIELD_W] =
              wdata_i[REG_W-1-(f%FIELDS_PER_REG)*FIELD_W -: FIELD_W];
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fields_q <= '0;
      ctrl_q   <= '0;
    end else begin
      fields_q <= fields_d;
      ctrl_q   <= ctrl_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (ctrl_sel) begin
      rdata_o = {nmi_level_i, {RSVD_W{1'b0}}, ctrl_q};
    end else begin
      for (int f = 0; f < FIELD_CNT; f++) begin
        if (addr_i == ADDR_W'(f / FIELDS_PER_REG)) begin
          rdata_o[REG_W-1-(f%FIELDS_PER_REG)*FIELD_W -: FIELD_W] =
            fields_q[f*FIELD_W +: FIELD_W];
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < IRQ_PINS; i++) begin
      sense_o[i] = ctrl_q[IRQ_PINS-1-i];
    end
  end

  assign fields_o   = fields_q;
  assign nmi_rise_o = ctrl_q[IRQ_PINS];

  // R10: a standby cycle leaves every register at its reset value
  assert_standby_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    standby_i |=> (fields_q == '0 && ctrl_q == '0));

  // R3: reserved control bits never read as 1
  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_sel |-> rdata_o[REG_W-2:CTRL_W] == '0);
endmodule

// File: rtl/prio_intc_detect.sv
module prio_intc_detect
  import prio_intc_pkg::*;
#(
  parameter int unsigned VEC_W   = 5,
  parameter int unsigned NMI_VEC = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IRQ_PINS-1:0] irq_sync_n_i,
  input  logic                nmi_sync_i,
  input  logic [IRQ_PINS-1:0] sense_i,
  input  logic                nmi_rise_i,
  input  logic                ack_i,
  input  logic [VEC_W-1:0]    ack_vec_i,
  output logic [IRQ_PINS-1:0] irq_pend_o,
  output logic                nmi_pend_o
);
  logic [IRQ_PINS-1:0] prev_q, prev_d;
  logic [IRQ_PINS-1:0] flag_q, flag_d;
  logic [IRQ_PINS-1:0] ack_hit;
  logic                nmi_prev_q, nmi_prev_d;
  logic                nmi_flag_q, nmi_flag_d;
  logic                nmi_ack, nmi_edge;

  always_comb begin
    prev_d = irq_sync_n_i;
    for (int i = 0; i < IRQ_PINS; i++) begin
      ack_hit[i] = ack_i && (ack_vec_i == VEC_W'(i));
      if (!sense_i[i]) begin
        flag_d[i]     = 1'b0;
        irq_pend_o[i] = ~irq_sync_n_i[i];
      end else begin
        flag_d[i]     = (flag_q[i] & ~ack_hit[i]) | (prev_q[i] & ~irq_sync_n_i[i]);
        irq_pend_o[i] = flag_q[i];
      end
    end
  end

  always_comb begin
    nmi_prev_d = nmi_sync_i;
    nmi_ack    = ack_i && (ack_vec_i == VEC_W'(NMI_VEC));
    nmi_edge   = nmi_rise_i ? (~nmi_prev_q & nmi_sync_i) : (nmi_prev_q & ~nmi_sync_i);
    nmi_flag_d = (nmi_flag_q & ~nmi_ack) | nmi_edge;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q     <= '1;
      flag_q     <= '0;
      nmi_prev_q <= 1'b1;
      nmi_flag_q <= 1'b0;
    end else begin
      prev_q     <= prev_d;
      flag_q     <= flag_d;
      nmi_prev_q <= nmi_prev_d;
      nmi_flag_q <= nmi_flag_d;
    end
  end

  assign nmi_pend_o = nmi_flag_q;

  for (genvar g = 0; g < IRQ_PINS; g++) begin : g_flag_chk
    // R5: a latched edge request ends only by its own acknowledge or a mode change
    assert_edge_flag_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_q[g]) |-> ($past(ack_hit[g]) || !$past(sense_i[g])));
  end

  // R9: the latched non-maskable request ends only by its acknowledge
  assert_nmi_flag_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nmi_flag_q) |-> $past(nmi_ack));
endmodule

// File: rtl/prio_intc_arb.sv
module prio_intc_arb
  import prio_intc_pkg::*;
#(
  parameter int unsigned SRC_CNT = 24,
  parameter int unsigned VEC_W   = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [SRC_CNT-1:0]         pend_i,
  input  logic [SRC_CNT*FIELD_W-1:0] prio_i,
  input  logic                       nmi_pend_i,
  output logic                       valid_o,
  output logic [LEVEL_W-1:0]         level_o,
  output logic [VEC_W-1:0]           vec_o
);
  logic [FIELD_W-1:0] best_lvl;
  logic [VEC_W-1:0]   best_vec;
  logic               valid_d, valid_q;
  logic [LEVEL_W-1:0] level_d, level_q;
  logic [VEC_W-1:0]   vec_d, vec_q;
  logic [SRC_CNT-1:0] live;

  always_comb begin
    best_lvl = '0;
    best_vec = '0;
    for (int i = 0; i < SRC_CNT; i++) begin
      live[i] = pend_i[i] && (prio_i[i*FIELD_W +: FIELD_W] != '0);
      if (pend_i[i] && (prio_i[i*FIELD_W +: FIELD_W] > best_lvl)) begin
        best_lvl = prio_i[i*FIELD_W +: FIELD_W];
        best_vec = VEC_W'(i);
      end
    end
    if (nmi_pend_i) begin
      valid_d = 1'b1;
      level_d = NMI_LEVEL;
      vec_d   = VEC_W'(SRC_CNT);
    end else begin
      valid_d = (best_lvl != '0);
      level_d = {1'b0, best_lvl};
      vec_d   = best_vec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      level_q <= '0;
      vec_q   <= '0;
    end else begin
      valid_q <= valid_d;
      level_q <= level_d;
      vec_q   <= vec_d;
    end
  end

  assign valid_o = valid_q;
  assign level_o = level_q;
  assign vec_o   = vec_q;

  // R9: a pending non-maskable request is reported next cycle at level 16
  assert_nmi_outranks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pend_i |=> (valid_q && level_q == NMI_LEVEL && vec_q == VEC_W'(SRC_CNT)));

  // R8: with no live request the output goes idle
  assert_zero_prio_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!nmi_pend_i && live == '0) |=> (!valid_q && level_q == '0));

  for (genvar s = 0; s < SRC_CNT; s++) begin : g_rank_chk
    // R7: the reported level is never below any live request
    assert_winner_not_lower_R7: assert property (@(posedge clk) disable iff (!rst_n)
      live[s] |=> (valid_q && level_q >= LEVEL_W'($past(prio_i[s*FIELD_W +: FIELD_W]))));
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import prio_intc_pkg::*;
#(
  parameter int unsigned GRP_CNT   = 8,
  parameter int unsigned GRP_LINES = 2,
  localparam int unsigned PER_LINES = GRP_CNT * GRP_LINES,
  localparam int unsigned SRC_CNT   = IRQ_PINS + PER_LINES,
  localparam int unsigned FIELD_CNT = IRQ_PINS + GRP_CNT,
  localparam int unsigned REG_CNT   = reg_count(FIELD_CNT),
  localparam int unsigned ADDR_W    = $clog2(REG_CNT + 1),
  localparam int unsigned VEC_W     = $clog2(SRC_CNT + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 standby_i,
  input  logic [IRQ_PINS-1:0]  irq_pin_n_i,
  input  logic                 nmi_pin_i,
  input  logic [PER_LINES-1:0] periph_req_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic                 bus_wr_i,
  input  logic [REG_W-1:0]     bus_wdata_i,
  output logic [REG_W-1:0]     bus_rdata_o,
  input  logic                 ack_i,
  input  logic [VEC_W-1:0]     ack_vec_i,
  output logic                 int_valid_o,
  output logic [LEVEL_W-1:0]   int_level_o,
  output logic [VEC_W-1:0]     int_vec_o
);
  logic                         rst_s1_q, rst_s2_q;
  logic                         rst_int_n;
  logic [IRQ_PINS:0]            pins_sync;
  logic [FIELD_CNT*FIELD_W-1:0] fields;
  logic [IRQ_PINS-1:0]          sense;
  logic                         nmi_rise;
  logic [IRQ_PINS-1:0]          irq_pend;
  logic                         nmi_pend;
  logic [SRC_CNT-1:0]           pend_all;
  logic [SRC_CNT*FIELD_W-1:0]   prio_src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_int_n = rst_s2_q;

  prio_intc_sync #(.W(IRQ_PINS + 1), .RST_VAL(1'b1)) u_sync (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .async_i ({nmi_pin_i, irq_pin_n_i}),
    .sync_o  (pins_sync)
  );

  prio_intc_regs #(.FIELD_CNT(FIELD_CNT), .REG_CNT(REG_CNT), .ADDR_W(ADDR_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .standby_i   (standby_i),
    .addr_i      (bus_addr_i),
    .wr_i        (bus_wr_i),
    .wdata_i     (bus_wdata_i),
    .nmi_level_i (pins_sync[IRQ_PINS]),
    .rdata_o     (bus_rdata_o),
    .fields_o    (fields),
    .sense_o     (sense),
    .nmi_rise_o  (nmi_rise)
  );

  prio_intc_detect #(.VEC_W(VEC_W), .NMI_VEC(SRC_CNT)) u_detect (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .irq_sync_n_i (pins_sync[IRQ_PINS-1:0]),
    .nmi_sync_i   (pins_sync[IRQ_PINS]),
    .sense_i      (sense),
    .nmi_rise_i   (nmi_rise),
    .ack_i        (ack_i),
    .ack_vec_i    (ack_vec_i),
    .irq_pend_o   (irq_pend),
    .nmi_pend_o   (nmi_pend)
  );

  assign pend_all = {periph_req_i, irq_pend};

  for (genvar p = 0; p < IRQ_PINS; p++) begin : g_pin_prio
    assign prio_src[p*FIELD_W +: FIELD_W] = fields[p*FIELD_W +: FIELD_W];
  end

  for (genvar g = 0; g < GRP_CNT; g++) begin : g_grp
    for (genvar j = 0; j < GRP_LINES; j++) begin : g_line
      localparam int unsigned SRC = IRQ_PINS + g * GRP_LINES + j;
      assign prio_src[SRC*FIELD_W +: FIELD_W] = fields[(IRQ_PINS + g)*FIELD_W +: FIELD_W];
    end
  end

  prio_intc_arb #(.SRC_CNT(SRC_CNT), .VEC_W(VEC_W)) u_arb (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .pend_i     (pend_all),
    .prio_i     (prio_src),
    .nmi_pend_i (nmi_pend),
    .valid_o    (int_valid_o),
    .level_o    (int_level_o),
    .vec_o      (int_vec_o)
  );
endmodule

// File: tb/prio_intc_tb_top.sv
module prio_intc_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        standby;
  logic [7:0]  irq_n;
  logic        nmi;
  logic [15:0] periph;
  logic [2:0]  bus_addr;
  logic        bus_wr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        ack;
  logic [4:0]  ack_vec;
  logic        int_valid;
  logic [4:0]  int_level;
  logic [4:0]  int_vec;

  int checks = 0;
  int fails  = 0;
  logic [15:0] shadow [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_intc dut_i (
    .clk(clk), .rst_n(rst_n), .standby_i(standby), .irq_pin_n_i(irq_n),
    .nmi_pin_i(nmi), .periph_req_i(periph), .bus_addr_i(bus_addr),
    .bus_wr_i(bus_wr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .ack_i(ack), .ack_vec_i(ack_vec), .int_valid_o(int_valid),
    .int_level_o(int_level), .int_vec_o(int_vec)
  );

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pk(input bit v, input int lvl, input int vec);
    return {21'b0, v, 5'(lvl), 5'(vec)};
  endfunction

  function automatic logic [31:0] outs();
    return {21'b0, int_valid, int_level, int_vec};
  endfunction

  task automatic wr(input int a, input logic [15:0] d);
    bus_addr = 3'(a); bus_wdata = d; bus_wr = 1'b1;
    tick(1);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    bus_addr = 3'(a);
    #1;
    d = bus_rdata;
  endtask

  task automatic set_field(input int f, input int v);
    shadow[f/4][15-4*(f%4) -: 4] = 4'(v);
    wr(f/4, shadow[f/4]);
  endtask

  task automatic ack_pulse(input int v);
    ack = 1'b1; ack_vec = 5'(v);
    tick(1);
    ack = 1'b0;
    tick(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] d;
    rst_n = 1'b0; standby = 1'b0; irq_n = 8'hFF; nmi = 1'b1; periph = '0;
    bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; ack = 1'b0; ack_vec = '0;
    for (int r = 0; r < 4; r++) shadow[r] = '0;
    tick(3);
    rst_n = 1'b1;
    tick(5);

    // R1 reset state
    for (int r = 0; r < 4; r++) begin rd(r, d); chk("R1 prio reg", d, 0); end
    rd(4, d); chk("R1 ctrl", d, 16'h8000);
    chk("R1 output idle", outs(), pk(0, 0, 0));

    // R2 field layout and readback
    for (int f = 0; f < 4; f++) set_field(f, f + 1);
    rd(0, d); chk("R2 nibble order", d, 16'h1234);
    for (int f = 0; f < 16; f++) set_field(f, (f * 7 + 3) % 16);
    for (int r = 0; r < 4; r++) begin rd(r, d); chk("R2 readback", d, shadow[r]); end
    for (int f = 0; f < 16; f++) set_field(f, 0);

    // R3 control register layout
    wr(4, 16'hFFFF);
    rd(4, d); chk("R3 reserved bits", d, 16'h81FF);
    wr(4, 16'h0000);
    rd(4, d); chk("R3 cleared", d, 16'h8000);

    // R11 latency of a level-sensed pin
    set_field(3, 5);
    irq_n[3] = 1'b0;
    tick(2); chk("R11 not before third edge", outs(), pk(0, 0, 0));
    tick(1); chk("R11 at third edge", outs(), pk(1, 5, 3));
    irq_n[3] = 1'b1;
    tick(3); chk("R4 release", outs(), pk(0, 0, 0));

    // R4 level sense on every pin
    for (int i = 0; i < 8; i++) set_field(i, 15 - i);
    for (int i = 0; i < 8; i++) begin
      irq_n[i] = 1'b0; tick(3);
      chk("R4 level request", outs(), pk(1, 15 - i, i));
      irq_n[i] = 1'b1; tick(3);
      chk("R4 level release", outs(), pk(0, 0, 0));
    end

    // R5 edge sense with latch and acknowledge
    wr(4, 16'h0010);
    irq_n[3] = 1'b0; tick(2);
    irq_n[3] = 1'b1; tick(5);
    chk("R5 latched after pin high", outs(), pk(1, 12, 3));
    ack_pulse(4);
    chk("R5 wrong ack ignored", outs(), pk(1, 12, 3));
    ack_pulse(3);
    chk("R5 ack clears", outs(), pk(0, 0, 0));
    wr(4, 16'h0000);
    for (int i = 0; i < 8; i++) set_field(i, 0);

    // R7 / R8 sweep over two groups (vectors 8 and 10)
    periph[0] = 1'b1; periph[2] = 1'b1;
    for (int pa = 0; pa < 16; pa++) begin
      for (int pb = 0; pb < 16; pb++) begin
        int m;
        set_field(8, pa); set_field(9, pb);
        tick(1);
        m = (pa >= pb) ? pa : pb;
        if (m == 0) chk("R8 zero priority silent", outs(), pk(0, 0, 0));
        else chk("R7 highest wins, tie lowest", outs(), pk(1, m, (pa >= pb) ? 8 : 10));
      end
    end
    periph = '0;
    set_field(8, 0); set_field(9, 0);

    // R6 shared group priority
    set_field(10, 9);
    periph[4] = 1'b1; tick(1);
    chk("R6 group line 0", outs(), pk(1, 9, 12));
    periph[4] = 1'b0; periph[5] = 1'b1; tick(1);
    chk("R6 group line 1", outs(), pk(1, 9, 13));
    periph[5] = 1'b0; periph[6] = 1'b1; tick(1);
    chk("R8 group with zero field", outs(), pk(0, 0, 0));
    periph[6] = 1'b0;

    // R9 non-maskable request
    set_field(8, 15); periph[0] = 1'b1; tick(1);
    chk("R9 baseline", outs(), pk(1, 15, 8));
    nmi = 1'b0; tick(4);
    chk("R9 falling edge outranks", outs(), pk(1, 16, 24));
    rd(4, d); chk("R3 pin level low", d, 16'h0000);
    ack_pulse(24);
    chk("R9 ack clears", outs(), pk(1, 15, 8));
    wr(4, 16'h0100);
    nmi = 1'b1; tick(4);
    chk("R9 rising edge selected", outs(), pk(1, 16, 24));
    ack_pulse(24);
    nmi = 1'b0; tick(4);
    chk("R9 falling ignored in rising mode", outs(), pk(1, 15, 8));
    wr(4, 16'h0000);
    nmi = 1'b1; tick(4);
    chk("R9 rising ignored in falling mode", outs(), pk(1, 15, 8));

    // R10 standby clears registers
    wr(4, 16'h01A5);
    standby = 1'b1; tick(1); standby = 1'b0;
    for (int r = 0; r < 4; r++) shadow[r] = '0;
    tick(1);
    for (int r = 0; r < 4; r++) begin rd(r, d); chk("R10 prio cleared", d, 0); end
    rd(4, d); chk("R10 ctrl cleared", d, 16'h8000);
    chk("R10 output idle", outs(), pk(0, 0, 0));
    periph = '0;

    summary();
    $finish;
  end
endmodule